// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits between a simple bus-write port and an embedded flash array. It watches every write for one of a small set of multi-cycle command sequences. Two of them start an erase: a logical-sector erase that names one sector, and a physical-sector erase that wipes a whole physical block. A physical block is either one of the program-flash blocks that hold the small sectors, or one data-flash bank. Two further single-write commands clear the sticky status and restore protection. A three-write unlock sequence carries two 32-bit passwords and lifts the write and read protection while it stays open.

Before an erase is launched, the block checks the target against the per-sector write-protect and one-time-programmable lock masks and against the global read-protect input. A refused erase raises a sticky protection-error flag and does not run. A sequence whose address or data is malformed is dropped without a trace. The analog erase and its quality check are outside the block. They answer each erase strobe with a done pulse, and a fail qualifier on that pulse raises a sticky verify-error flag.

Address bit 19 picks the region (0 = program flash, 1 = data flash). Bits 18:0 are the offset inside the region. Sectors are numbered as bits of a 13-bit mask:
- Bits 0 to 7 are 16 KiB program sectors at offsets 0x00000 to 0x1FFFF.
- Bits 8 to 10 are 128 KiB program sectors from offset 0x20000 upward.
- Bits 11 and 12 are the 64 KiB data banks at data offsets 0x00000 and 0x10000.

Top module: `flash_erase_seq`

## Requirements
- R1: While rstN is low and on the first cycle after it rises, eraseStart, eraseMask, erasePhys, busy, protErr, verErr and protOpen are all zero.
- R2: The erase sequence is six writes. They are (offset 0x0AA, data 0xAA), (0x055, 0x55), (0x0AA, 0x80), (0x0AA, 0xAA), (0x055, 0x55), and a final write to the sector address. A final data of 0x30 requests a logical erase of the sector that holds that address, at any address inside it. On the clock edge that takes the final write, the block raises eraseStart for exactly one cycle and raises busy. eraseMask then carries that sector's single bit and erasePhys is 0.
- R3: A final data of 0x40 requests a physical erase. Program offset 0x00000 selects mask bits 0 to 3 and program offset 0x10000 selects bits 4 to 7. Data offsets 0x00000 and 0x10000 select bits 11 and 12. erasePhys is 1.
- R4: A physical erase whose sector address has any of its low 16 bits set, or that lies in the large program sectors or beyond the data banks, starts nothing and sets no flag. A logical erase beyond the data banks does the same.
- R5: A write with the wrong offset or data at any step after the first drops the sequence without setting a flag. The next write is then decoded as a first step.
- R6: Every write of a sequence must carry the same region bit as the first write, the sector address included. On a mismatch the sequence is dropped with no start and no flag.
- R7: While protection is not open, an erase is refused and protErr is set if any target sector has its protWrMask bit set or if readProtEn is 1.
- R8: The unlock sequence is (0x0AA, 0xA5), (0x055, first password), (0x055, second password). It sets protOpen only when the two data words equal pwdA and pwdB. Otherwise it sets protErr and protOpen stays 0. A single write of 0x5E to offset 0x0AA clears protOpen.
- R9: An erase whose target includes a sector with its otpMask bit set is always refused with protErr, even while protOpen is 1.
- R10: busy stays high from the start until an eraseDone pulse. If eraseFail is 1 on that pulse, verErr is set. All writes are ignored while busy is high.
- R11: protErr and verErr stay set until reset or until a single write of 0xF5 to offset 0x0AA, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A bus write is present this cycle |
| wrAddr | input | 20 | Write address; bit 19 is the region |
| wrData | input | 32 | Write data |
| pwdA | input | 32 | Stored first password |
| pwdB | input | 32 | Stored second password |
| protWrMask | input | 13 | Per-sector write protection |
| otpMask | input | 13 | Per-sector permanent lock |
| readProtEn | input | 1 | Global read protection is installed |
| eraseDone | input | 1 | Erase engine finished |
| eraseFail | input | 1 | Quality check failed, qualifies eraseDone |
| eraseStart | output | 1 | One-cycle erase launch strobe |
| eraseMask | output | 13 | Sectors of the current erase |
| erasePhys | output | 1 | Current erase is a physical erase |
| busy | output | 1 | Erase in progress |
| protErr | output | 1 | Sticky protection error |
| verErr | output | 1 | Sticky verify error |
| protOpen | output | 1 | Protection lifted by unlock |

## Verification
The bench sends erase sequences with sector addresses at the first and last byte of sectors, at the region's upper boundary, and one step off physical alignment. A design that decoded sector indices with an off-by-one shift, or that accepted unaligned physical erases, would show a wrong mask or a start where none belongs. It also breaks sequences in the middle: wrong data at a step, and a region flip at a middle step or on the sector address. A decoder that failed to return to idle, or that ignored the region, would either miss the next valid sequence or launch an erase. Protection is exercised with one password wrong, with read protection alone, with a locked sector that stays refused after unlock, and with writes sent while an erase is running. A design that leaked any of these would raise a start, clear a flag early, or leave protOpen in the wrong state.

// File: rtl/fes_pkg.sv
package fes_pkg;

  // Command offsets inside a region
  localparam logic [31:0] CMD_OFF_A = 32'h0000_00AA;
  localparam logic [31:0] CMD_OFF_B = 32'h0000_0055;

  // Data codes of the command steps
  localparam logic [31:0] CODE_OPEN    = 32'h0000_00AA;
  localparam logic [31:0] CODE_ACK     = 32'h0000_0055;
  localparam logic [31:0] CODE_ERASE   = 32'h0000_0080;
  localparam logic [31:0] CODE_LOGICAL = 32'h0000_0030;
  localparam logic [31:0] CODE_PHYS    = 32'h0000_0040;
  localparam logic [31:0] CODE_UNLOCK  = 32'h0000_00A5;
  localparam logic [31:0] CODE_CLEAR   = 32'h0000_00F5;
  localparam logic [31:0] CODE_RELOCK  = 32'h0000_005E;

  // Control to datapath strobes
  typedef struct packed {
    logic latchRegion;
    logic launch;
    logic launchPhys;
    logic pwdFirst;
    logic pwdCheck;
    logic relock;
    logic clrStatus;
  } fesStrobes_t;

  // Datapath to control: decoded view of the current write
  typedef struct packed {
    logic offA;
    logic offB;
    logic sameRegion;
  } fesCycInfo_t;

endpackage

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic [31:0] wrData,
  input  fesCycInfo_t cyc,
  input  logic        busy,
  output fesStrobes_t strb
);

  typedef enum logic [2:0] {
    S_IDLE, S_E1, S_E2, S_E3, S_E4, S_E5, S_U1, S_U2
  } seqState_t;

  seqState_t state, nextState;
  logic      take;

  assign take = wrValid && !busy;

  always_comb begin
    nextState = state;
    strb      = '0;
    if (take) begin
      unique case (state)
        S_IDLE: begin
          if (cyc.offA) begin
            if (wrData == CODE_OPEN) begin
              nextState        = S_E1;
              strb.latchRegion = 1'b1;
            end else if (wrData == CODE_UNLOCK) begin
              nextState        = S_U1;
              strb.latchRegion = 1'b1;
            end else if (wrData == CODE_CLEAR) begin
              strb.clrStatus = 1'b1;
            end else if (wrData == CODE_RELOCK) begin
              strb.relock = 1'b1;
            end
          end
        end
        S_E1: nextState = (cyc.offB && cyc.sameRegion && wrData == CODE_ACK)   ? S_E2 : S_IDLE;
        S_E2: nextState = (cyc.offA && cyc.sameRegion && wrData == CODE_ERASE) ? S_E3 : S_IDLE;
        S_E3: nextState = (cyc.offA && cyc.sameRegion && wrData == CODE_OPEN)  ? S_E4 : S_IDLE;
        S_E4: nextState = (cyc.offB && cyc.sameRegion && wrData == CODE_ACK)   ? S_E5 : S_IDLE;
        S_E5: begin
          nextState = S_IDLE;
          if (cyc.sameRegion) begin
            if (wrData == CODE_LOGICAL) begin
              strb.launch = 1'b1;
            end else if (wrData == CODE_PHYS) begin
              strb.launch     = 1'b1;
              strb.launchPhys = 1'b1;
            end
          end
        end
        S_U1: begin
          nextState = S_IDLE;
          if (cyc.offB && cyc.sameRegion) begin
            nextState     = S_U2;
            strb.pwdFirst = 1'b1;
          end
        end
        S_U2: begin
          nextState = S_IDLE;
          if (cyc.offB && cyc.sameRegion) strb.pwdCheck = 1'b1;
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  AST_IDLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> state == S_IDLE); // R10

  AST_LAUNCH_FROM_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |=> state == S_IDLE); // R2

endmodule

// File: rtl/fes_datapath.sv
module fes_datapath
  import fes_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int SMALL_LOG2     = 14,
  parameter int NUM_SMALL      = 8,
  parameter int SMALL_PER_PHYS = 4,
  parameter int LARGE_LOG2     = 17,
  parameter int NUM_LARGE      = 3,
  parameter int DF_LOG2        = 16,
  parameter int NUM_DF         = 2,
  localparam int NUM_SECT      = NUM_SMALL + NUM_LARGE + NUM_DF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [31:0]         wrData,
  input  fesStrobes_t         strb,
  input  logic [31:0]         pwdA,
  input  logic [31:0]         pwdB,
  input  logic [NUM_SECT-1:0] protWrMask,
  input  logic [NUM_SECT-1:0] otpMask,
  input  logic                readProtEn,
  input  logic                eraseDone,
  input  logic                eraseFail,
  output fesCycInfo_t         cyc,
  output logic                eraseStart,
  output logic [NUM_SECT-1:0] eraseMask,
  output logic                erasePhys,
  output logic                busy,
  output logic                protErr,
  output logic                verErr,
  output logic                protOpen
);

  localparam int          PHYS_LOG2 = SMALL_LOG2 + $clog2(SMALL_PER_PHYS);
  localparam logic [31:0] SPP       = 32'(SMALL_PER_PHYS);
  localparam logic [31:0] SMALL_END = 32'(NUM_SMALL) << SMALL_LOG2;
  localparam logic [31:0] LARGE_END = SMALL_END + (32'(NUM_LARGE) << LARGE_LOG2);
  localparam logic [31:0] DF_END    = 32'(NUM_DF) << DF_LOG2;
  localparam logic [31:0] DF_BASE   = 32'(NUM_SMALL + NUM_LARGE);
  localparam logic [31:0] PHYS_LOW  = (32'd1 << PHYS_LOG2) - 32'd1;
  localparam logic [31:0] DF_LOW    = (32'd1 << DF_LOG2) - 32'd1;

  logic                region, regionQ, pwdOkQ;
  logic [31:0]         offInt, selLo, selCnt;
  logic                tgtOk, blocked;
  logic [NUM_SECT-1:0] tgtMask;

  assign region = wrAddr[ADDR_W-1];
  assign offInt = 32'(wrAddr[ADDR_W-2:0]);

  assign cyc.offA       = (offInt == CMD_OFF_A);
  assign cyc.offB       = (offInt == CMD_OFF_B);
  assign cyc.sameRegion = (region == regionQ);

  // Target decode: first sector index and sector count of the request
  always_comb begin
    tgtOk  = 1'b0;
    selLo  = '0;
    selCnt = 32'd1;
    if (!region) begin
      if (offInt < SMALL_END) begin
        if (!strb.launchPhys) begin
          tgtOk = 1'b1;
          selLo = offInt >> SMALL_LOG2;
        end else if ((offInt & PHYS_LOW) == '0) begin
          tgtOk  = 1'b1;
          selLo  = (offInt >> PHYS_LOG2) * SPP;
          selCnt = SPP;
        end
      end else if (!strb.launchPhys && offInt < LARGE_END) begin
        tgtOk = 1'b1;
        selLo = DF_BASE - 32'(NUM_LARGE) + ((offInt - SMALL_END) >> LARGE_LOG2);
      end
    end else if (offInt < DF_END) begin
      if (!strb.launchPhys || (offInt & DF_LOW) == '0) begin
        tgtOk = 1'b1;
        selLo = DF_BASE + (offInt >> DF_LOG2);
      end
    end
  end

  for (genvar gi = 0; gi < NUM_SECT; gi++) begin : g_sel
    assign tgtMask[gi] = tgtOk && (32'(gi) >= selLo) && (32'(gi) < selLo + selCnt);
  end

  assign blocked = (|(tgtMask & otpMask)) ||
                   (!protOpen && (readProtEn || (|(tgtMask & protWrMask))));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionQ    <= 1'b0;
      pwdOkQ     <= 1'b0;
      protOpen   <= 1'b0;
      busy       <= 1'b0;
      eraseStart <= 1'b0;
      eraseMask  <= '0;
      erasePhys  <= 1'b0;
      protErr    <= 1'b0;
      verErr     <= 1'b0;
    end else begin
      eraseStart <= 1'b0;
      if (strb.latchRegion) regionQ <= region;
      if (strb.pwdFirst)    pwdOkQ  <= (wrData == pwdA);
      if (strb.pwdCheck) begin
        if (pwdOkQ && wrData == pwdB) protOpen <= 1'b1;
        else                          protErr  <= 1'b1;
      end
      if (strb.relock) protOpen <= 1'b0;
      if (strb.clrStatus) begin
        protErr <= 1'b0;
        verErr  <= 1'b0;
      end
      if (strb.launch && tgtOk) begin
        if (blocked) begin
          protErr <= 1'b1;
        end else begin
          eraseStart <= 1'b1;
          busy       <= 1'b1;
          eraseMask  <= tgtMask;
          erasePhys  <= strb.launchPhys;
        end
      end
      if (busy && eraseDone) begin
        busy <= 1'b0;
        if (eraseFail) verErr <= 1'b1;
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart); // R2

  AST_START_HAS_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> eraseMask != '0); // R2

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> busy); // R10

  AST_NO_OTP_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> (eraseMask & $past(otpMask)) == '0); // R9

  AST_VERIFY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(verErr) |-> $past(busy && eraseDone && eraseFail)); // R10

  AST_OPEN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protOpen) |-> $past(strb.pwdCheck)); // R8

  AST_PROTERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protErr) |-> $past(strb.launch || strb.pwdCheck)); // R7

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStatus |=> !protErr && !verErr); // R11

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int SMALL_LOG2     = 14,
  parameter int NUM_SMALL      = 8,
  parameter int SMALL_PER_PHYS = 4,
  parameter int LARGE_LOG2     = 17,
  parameter int NUM_LARGE      = 3,
  parameter int DF_LOG2        = 16,
  parameter int NUM_DF         = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  wrValid,
  input  logic [ADDR_W-1:0]                     wrAddr,
  input  logic [31:0]                           wrData,
  input  logic [31:0]                           pwdA,
  input  logic [31:0]                           pwdB,
  input  logic [NUM_SMALL+NUM_LARGE+NUM_DF-1:0] protWrMask,
  input  logic [NUM_SMALL+NUM_LARGE+NUM_DF-1:0] otpMask,
  input  logic                                  readProtEn,
  input  logic                                  eraseDone,
  input  logic                                  eraseFail,
  output logic                                  eraseStart,
  output logic [NUM_SMALL+NUM_LARGE+NUM_DF-1:0] eraseMask,
  output logic                                  erasePhys,
  output logic                                  busy,
  output logic                                  protErr,
  output logic                                  verErr,
  output logic                                  protOpen
);

  fesStrobes_t strb;
  fesCycInfo_t cyc;

  fes_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrValid (wrValid),
    .wrData  (wrData),
    .cyc     (cyc),
    .busy    (busy),
    .strb    (strb)
  );

  fes_datapath #(
    .ADDR_W         (ADDR_W),
    .SMALL_LOG2     (SMALL_LOG2),
    .NUM_SMALL      (NUM_SMALL),
    .SMALL_PER_PHYS (SMALL_PER_PHYS),
    .LARGE_LOG2     (LARGE_LOG2),
    .NUM_LARGE      (NUM_LARGE),
    .DF_LOG2        (DF_LOG2),
    .NUM_DF         (NUM_DF)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .strb       (strb),
    .pwdA       (pwdA),
    .pwdB       (pwdB),
    .protWrMask (protWrMask),
    .otpMask    (otpMask),
    .readProtEn (readProtEn),
    .eraseDone  (eraseDone),
    .eraseFail  (eraseFail),
    .cyc        (cyc),
    .eraseStart (eraseStart),
    .eraseMask  (eraseMask),
    .erasePhys  (erasePhys),
    .busy       (busy),
    .protErr    (protErr),
    .verErr     (verErr),
    .protOpen   (protOpen)
  );

endmodule

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;

  localparam logic [31:0] PWD0 = 32'h1357_9BDF;
  localparam logic [31:0] PWD1 = 32'h2468_ACE0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [19:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [12:0] protWrMask = '0;
  logic [12:0] otpMask = '0;
  logic        readProtEn = 1'b0;
  logic        eraseDone = 1'b0;
  logic        eraseFail = 1'b0;
  logic        eraseStart, erasePhys, busy, protErr, verErr, protOpen;
  logic [12:0] eraseMask;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  flash_erase_seq dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .pwdA(PWD0), .pwdB(PWD1), .protWrMask(protWrMask), .otpMask(otpMask),
    .readProtEn(readProtEn), .eraseDone(eraseDone), .eraseFail(eraseFail),
    .eraseStart(eraseStart), .eraseMask(eraseMask), .erasePhys(erasePhys),
    .busy(busy), .protErr(protErr), .verErr(verErr), .protOpen(protOpen)
  );

  typedef struct packed {
    logic        phys;
    logic [19:0] sa;
    logic        expStart;
    logic [12:0] expMask;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 20'h00000, 1'b1, 13'h0001},
    '{1'b0, 20'h0C123, 1'b1, 13'h0008},
    '{1'b0, 20'h1FFFF, 1'b1, 13'h0080},
    '{1'b0, 20'h20000, 1'b1, 13'h0100},
    '{1'b0, 20'h7FFF0, 1'b1, 13'h0400},
    '{1'b0, 20'h92345, 1'b1, 13'h1000},
    '{1'b1, 20'h00000, 1'b1, 13'h000F},
    '{1'b1, 20'h10000, 1'b1, 13'h00F0},
    '{1'b1, 20'h80000, 1'b1, 13'h0800},
    '{1'b1, 20'h90000, 1'b1, 13'h1000},
    '{1'b1, 20'h04000, 1'b0, 13'h0000},
    '{1'b1, 20'h20000, 1'b0, 13'h0000},
    '{1'b1, 20'h80100, 1'b0, 13'h0000},
    '{1'b0, 20'hA0000, 1'b0, 13'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrAddr  = a;
    wrData  = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic prefix(input logic r);
    wr({r, 19'h000AA}, 32'hAA);
    wr({r, 19'h00055}, 32'h55);
    wr({r, 19'h000AA}, 32'h80);
    wr({r, 19'h000AA}, 32'hAA);
    wr({r, 19'h00055}, 32'h55);
  endtask

  task automatic seqErase(input logic r, input logic [19:0] sa, input logic phys);
    prefix(r);
    wr(sa, phys ? 32'h40 : 32'h30);
  endtask

  task automatic unlock(input logic [31:0] p0, input logic [31:0] p1);
    wr(20'h000AA, 32'hA5);
    wr(20'h00055, p0);
    wr(20'h00055, p1);
  endtask

  task automatic clearStatus();
    wr(20'h000AA, 32'hF5);
  endtask

  task automatic finishErase(input logic fail);
    @(negedge clk);
    eraseDone = 1'b1;
    eraseFail = fail;
    @(negedge clk);
    eraseDone = 1'b0;
    eraseFail = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", 32'({eraseStart, eraseMask, erasePhys, busy, protErr, verErr, protOpen}), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", 32'({eraseStart, eraseMask, erasePhys, busy, protErr, verErr, protOpen}), 32'h0);

    // R2 R3 R4 table walk
    for (int i = 0; i < NVEC; i++) begin
      seqErase(VEC[i].sa[19], VEC[i].sa, VEC[i].phys);
      check($sformatf("R2 R3 R4 vec %0d start", i), 32'(eraseStart), 32'(VEC[i].expStart));
      check($sformatf("R2 R3 R4 vec %0d protErr", i), 32'(protErr), 32'h0);
      if (VEC[i].expStart) begin
        check($sformatf("R2 R3 vec %0d mask", i), 32'(eraseMask), 32'(VEC[i].expMask));
        check($sformatf("R2 R3 vec %0d phys", i), 32'(erasePhys), 32'(VEC[i].phys));
        check($sformatf("R10 vec %0d busy", i), 32'(busy), 32'h1);
        finishErase(1'b0);
        check($sformatf("R10 vec %0d done", i), 32'({busy, verErr}), 32'h0);
      end else begin
        check($sformatf("R4 vec %0d idle", i), 32'(busy), 32'h0);
      end
    end

    // R2 start is a single-cycle pulse
    seqErase(1'b0, 20'h04000, 1'b0);
    @(negedge clk);
    check("R2 pulse width", 32'({eraseStart, busy}), 32'h1);
    finishErase(1'b0);

    // R5 wrong data mid-sequence aborts silently, then a fresh sequence works
    wr(20'h000AA, 32'hAA);
    wr(20'h00055, 32'h55);
    wr(20'h000AA, 32'h81);
    check("R5 abort no flags", 32'({eraseStart, busy, protErr}), 32'h0);
    seqErase(1'b0, 20'h08000, 1'b0);
    check("R5 fresh sequence start", 32'(eraseMask), 32'h0004);
    finishErase(1'b0);
    // R5 wrong offset in step four
    wr(20'h000AA, 32'hAA);
    wr(20'h00055, 32'h55);
    wr(20'h000AA, 32'h80);
    wr(20'h00055, 32'hAA);
    wr(20'h00055, 32'h55);
    wr(20'h00000, 32'h30);
    check("R5 wrong offset no start", 32'({eraseStart, busy, protErr}), 32'h0);

    // R6 sector address in the other region
    seqErase(1'b0, 20'h80000, 1'b1);
    check("R6 region mismatch SA", 32'({eraseStart, busy, protErr}), 32'h0);
    // R6 middle step in the other region
    wr(20'h000AA, 32'hAA);
    wr(20'h80055, 32'h55);
    wr(20'h000AA, 32'h80);
    wr(20'h000AA, 32'hAA);
    wr(20'h00055, 32'h55);
    wr(20'h00000, 32'h30);
    check("R6 region mismatch step", 32'({eraseStart, busy, protErr}), 32'h0);

    // R7 write protection
    protWrMask = 13'h0004;
    seqErase(1'b0, 20'h08000, 1'b0);
    check("R7 protected refused", 32'({eraseStart, busy, protErr}), 32'h1);
    // R11 sticky across an unrelated good erase, then cleared
    seqErase(1'b0, 20'h00000, 1'b0);
    check("R11 protErr sticky", 32'({eraseStart, protErr}), 32'h3);
    finishErase(1'b0);
    clearStatus();
    check("R11 clear status", 32'({protErr, verErr}), 32'h0);
    // R7 read protection blocks every sector
    readProtEn = 1'b1;
    seqErase(1'b0, 20'h00000, 1'b0);
    check("R7 read protect refused", 32'({eraseStart, busy, protErr}), 32'h1);
    clearStatus();

    // R8 wrong first password
    unlock(32'h0BAD_0BAD, PWD1);
    check("R8 bad password", 32'({protOpen, protErr}), 32'h1);
    clearStatus();
    // R8 good passwords
    unlock(PWD0, PWD1);
    check("R8 unlock open", 32'({protOpen, protErr}), 32'h2);
    seqErase(1'b0, 20'h08000, 1'b0);
    check("R8 protected sector after unlock", 32'({eraseStart, protErr}), 32'h2);
    check("R8 protected sector mask", 32'(eraseMask), 32'h0004);
    finishErase(1'b0);

    // R9 locked sector refused even while open
    otpMask = 13'h0800;
    seqErase(1'b1, 20'h80000, 1'b1);
    check("R9 otp bank refused", 32'({eraseStart, busy, protErr}), 32'h1);
    clearStatus();
    otpMask = 13'h0002;
    seqErase(1'b0, 20'h00000, 1'b1);
    check("R9 otp inside physical block", 32'({eraseStart, busy, protErr}), 32'h1);
    clearStatus();
    otpMask = '0;

    // R8 relock closes protection again
    wr(20'h000AA, 32'h5E);
    check("R8 relock", 32'(protOpen), 32'h0);
    seqErase(1'b0, 20'h08000, 1'b0);
    check("R8 relocked refuses", 32'({eraseStart, protErr}), 32'h1);
    readProtEn = 1'b0;
    protWrMask = '0;

    // R10 writes ignored while busy; verify failure
    seqErase(1'b0, 20'h04000, 1'b0);
    clearStatus();
    check("R10 clear ignored while busy", 32'({busy, protErr}), 32'h3);
    seqErase(1'b1, 20'h80000, 1'b1);
    check("R10 sequence ignored while busy", 32'({eraseStart, eraseMask, erasePhys}), 32'({1'b0, 13'h0002, 1'b0}));
    finishErase(1'b1);
    check("R10 verify error", 32'({busy, verErr}), 32'h1);
    seqErase(1'b0, 20'h00000, 1'b0);
    finishErase(1'b0);
    check("R11 verErr sticky", 32'(verErr), 32'h1);
    clearStatus();
    check("R11 verErr cleared", 32'({protErr, verErr}), 32'h0);

    // R11 reset also clears flags
    seqErase(1'b0, 20'h00000, 1'b0);
    finishErase(1'b1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R11 reset clears", 32'({verErr, protErr, busy}), 32'h0);

    summary();
  end

endmodule